// File: doc/BRIEF.md
# Streaming Row Predicate Filter

This block screens database table rows as they stream past. A row arrives as a run of 32-bit column values, one value per beat, with a marker on its first and its last beat. Sixteen comparators each test one chosen column of the row against a constant. Their results are combined as an OR of four AND groups. A row that satisfies the combined condition is sent on whole to an output stream. A row that fails is discarded.

Before a run, software writes each comparator's column number, operator, constant and enable bit through a simple write port. A one-cycle `start` pulse opens a run. The last beat of the last row carries an end-of-table flag. Once that row is settled, the block raises `ack` for one cycle and returns to idle. A cycle counter measures the run from start to acknowledge, and its value stays readable afterwards.

Each row is stored in a 32-entry buffer as it arrives. The decision is made on the row's last beat, and a passing row is then replayed from the buffer under valid/ready flow control. The input is held off while a row drains.

Top module: `rowsel_filter`

## Requirements
- R1: After reset, `out_valid`, `ack`, `busy` and `in_ready` are all 0, and they stay at 0 until `start` is seen.
- R2: A `start` pulse in idle opens a run. From the next cycle `busy` is 1, and `in_ready` is 1 whenever no row is draining.
- R3: A comparator's 3-bit operator code selects a signed 32-bit test of column value against constant: 0 equal, 1 not equal, 2 less, 3 less-or-equal, 4 greater, 5 greater-or-equal. Codes 6 and 7 always give false.
- R4: A comparator tests the beat whose zero-based position in the row matches its column field. The beat flagged `in_first` is position 0. If the row is too short to contain that column, the comparator gives false for that row.
- R5: Comparators 4g to 4g+3 form AND group g, for g = 0 to 3. A comparator whose enable bit is 0 counts as true inside its group. The row passes when any group is true.
- R6: A group with no enabled comparator counts as false. With every comparator disabled, no row passes.
- R7: A passing row is emitted with all its beats in arrival order. `out_first` is set on the first beat and `out_last` on the final beat. A failing row produces no output beat.
- R8: While `out_valid` is 1 and `out_ready` is 0, the output beat is held unchanged. No input beat is accepted while a row is draining.
- R9: After the row carrying `in_eot` has either drained or been dropped, `ack` is 1 for exactly one cycle. The block is then idle.
- R10: `cyc_count` is cleared by `start` and rises by one for each cycle in which `busy` is 1. It holds its value after the run ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Writes one comparator's settings |
| cfg_sel | input | 4 | Comparator number to write |
| cfg_col | input | 5 | Column position that the comparator tests |
| cfg_op | input | 3 | Operator code (see R3) |
| cfg_en | input | 1 | Comparator enable |
| cfg_k | input | 32 | Comparison constant |
| start | input | 1 | Opens a run |
| busy | output | 1 | A run is in progress |
| ack | output | 1 | One-cycle end-of-run pulse |
| cyc_count | output | 32 | Cycles spent in the last or current run |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat accepted when high |
| in_data | input | 32 | Column value |
| in_first | input | 1 | First beat of a row |
| in_last | input | 1 | Last beat of a row |
| in_eot | input | 1 | Last row of the table (read with in_last) |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the beat |
| out_data | output | 32 | Column value of a passing row |
| out_first | output | 1 | First beat of an emitted row |
| out_last | output | 1 | Last beat of an emitted row |

## Verification
A row's last beat can also be the column that a comparator tests. That comparison and the pass decision must then be resolved in the same cycle. Rows with random lengths are sent with a comparator on column 5, so that a six-beat row sets this up, and single-beat rows in the operator sweep decide on their only beat. The drain of the table's final row can also coincide with the end-of-run acknowledge. The bench checks that `ack` comes only once the scoreboard queue is empty, that it drops on the next cycle, and that the cycle counter matches the number of busy cycles it counted on its own.

// File: rtl/rowsel_pkg.sv
package rowsel_pkg;
  localparam int DATA_W = 32;
  localparam int N_PRED = 16;
  localparam int GRP_SZ = 4;
  localparam int N_GRP  = N_PRED / GRP_SZ;
  localparam int SEL_W  = $clog2(N_PRED);

  typedef enum logic [2:0] {
    OP_EQ = 3'd0, OP_NE = 3'd1, OP_LT = 3'd2,
    OP_LE = 3'd3, OP_GT = 3'd4, OP_GE = 3'd5
  } cmp_op_e;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN, S_DONE} run_st_e;

  // signed compare of a column value against a constant
  function automatic logic cmp_eval(input logic [2:0] op,
                                    input logic [DATA_W-1:0] v,
                                    input logic [DATA_W-1:0] k);
    logic signed [DATA_W-1:0] sv, sk;
    sv = v;
    sk = k;
    case (op)
      OP_EQ:   return sv == sk;
      OP_NE:   return sv != sk;
      OP_LT:   return sv <  sk;
      OP_LE:   return sv <= sk;
      OP_GT:   return sv >  sk;
      OP_GE:   return sv >= sk;
      default: return 1'b0;
    endcase
  endfunction

  // OR over groups; a group counts only if it holds an enabled predicate
  function automatic logic groups_pass(input logic [N_PRED-1:0] en,
                                       input logic [N_PRED-1:0] ok);
    logic any;
    any = 1'b0;
    for (int g = 0; g < N_GRP; g++)
      any |= (|en[g*GRP_SZ +: GRP_SZ]) & (&ok[g*GRP_SZ +: GRP_SZ]);
    return any;
  endfunction
endpackage

// File: rtl/rowsel_pred.sv
module rowsel_pred
  import rowsel_pkg::*;
#(
  parameter int IDXW = 5,
  parameter int CNTW = IDXW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDXW-1:0]   cfg_col,
  input  logic [2:0]        cfg_op,
  input  logic              cfg_en,
  input  logic [DATA_W-1:0] cfg_k,
  input  logic              beat_fire,
  input  logic              beat_first,
  input  logic [CNTW-1:0]   beat_idx,
  input  logic [DATA_W-1:0] beat_data,
  output logic              en_o,
  output logic              pass_o
);
  logic [IDXW-1:0]   col_q;
  logic [2:0]        op_q;
  logic              en_q;
  logic [DATA_W-1:0] k_q;
  logic              res_q;
  logic              col_hit;
  logic              cmp_now;
  logic              res_now;

  always_comb begin
    col_hit = beat_fire && (beat_idx == CNTW'(col_q));
    cmp_now = cmp_eval(op_q, beat_data, k_q);
    if (col_hit)                     res_now = cmp_now;
    else if (beat_fire && beat_first) res_now = 1'b0;
    else                             res_now = res_q;
    en_o   = en_q;
    pass_o = !en_q || res_now;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q <= '0;
      op_q  <= '0;
      en_q  <= 1'b0;
      k_q   <= '0;
      res_q <= 1'b0;
    end else begin
      if (cfg_we) begin
        col_q <= cfg_col;
        op_q  <= cfg_op;
        en_q  <= cfg_en;
        k_q   <= cfg_k;
      end
      if (beat_fire) res_q <= res_now;
    end
  end

  // R4: a row start on a non-zero column leaves the result false
  p_row_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && beat_first && col_q != '0 && !cfg_we) |=> !res_q);
endmodule

// File: rtl/rowsel_rowbuf.sv
module rowsel_rowbuf #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rowsel_filter.sv
module rowsel_filter
  import rowsel_pkg::*;
#(
  parameter int MAX_COLS = 32,
  parameter int CYCW     = 32,
  parameter int IDXW     = $clog2(MAX_COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [IDXW-1:0]   cfg_col,
  input  logic [2:0]        cfg_op,
  input  logic              cfg_en,
  input  logic [DATA_W-1:0] cfg_k,
  input  logic              start,
  output logic              busy,
  output logic              ack,
  output logic [CYCW-1:0]   cyc_count,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_first,
  input  logic              in_last,
  input  logic              in_eot,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_first,
  output logic              out_last
);
  localparam int CNTW = IDXW + 1;

  run_st_e           state;
  logic [CNTW-1:0]   wr_cnt, beat_idx, len_q, rd_ptr;
  logic              eot_q;
  logic              in_fire, out_fire, row_done, row_pass;
  logic [N_PRED-1:0] pred_en, pred_pass;

  always_comb begin
    in_ready  = (state == S_RUN);
    in_fire   = in_valid && in_ready;
    beat_idx  = in_first ? '0 : wr_cnt;
    row_done  = in_fire && in_last;
    row_pass  = groups_pass(pred_en, pred_pass);
    out_valid = (state == S_DRAIN);
    out_fire  = out_valid && out_ready;
    out_first = out_valid && (rd_ptr == '0);
    out_last  = out_valid && (rd_ptr == len_q - CNTW'(1));
    busy      = (state != S_IDLE);
    ack       = (state == S_DONE);
  end

  for (genvar p = 0; p < N_PRED; p++) begin : g_pred
    rowsel_pred #(.IDXW(IDXW), .CNTW(CNTW)) u_pred (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we && cfg_sel == SEL_W'(p)),
      .cfg_col(cfg_col), .cfg_op(cfg_op), .cfg_en(cfg_en), .cfg_k(cfg_k),
      .beat_fire(in_fire), .beat_first(in_first), .beat_idx(beat_idx),
      .beat_data(in_data), .en_o(pred_en[p]), .pass_o(pred_pass[p])
    );
  end

  rowsel_rowbuf #(.DW(DATA_W), .DEPTH(MAX_COLS), .AW(IDXW)) u_buf (
    .clk(clk), .we(in_fire), .waddr(beat_idx[IDXW-1:0]), .wdata(in_data),
    .raddr(rd_ptr[IDXW-1:0]), .rdata(out_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      wr_cnt    <= '0;
      len_q     <= '0;
      rd_ptr    <= '0;
      eot_q     <= 1'b0;
      cyc_count <= '0;
    end else begin
      if (busy) cyc_count <= cyc_count + CYCW'(1);
      case (state)
        S_IDLE: if (start) begin
          state     <= S_RUN;
          cyc_count <= '0;
          wr_cnt    <= '0;
        end
        S_RUN: if (in_fire) begin
          wr_cnt <= beat_idx + CNTW'(1);
          if (in_last) begin
            if (row_pass) begin
              state  <= S_DRAIN;
              len_q  <= beat_idx + CNTW'(1);
              rd_ptr <= '0;
              eot_q  <= in_eot;
            end else if (in_eot) begin
              state <= S_DONE;
            end
          end
        end
        S_DRAIN: if (out_fire) begin
          rd_ptr <= rd_ptr + CNTW'(1);
          if (out_last) state <= eot_q ? S_DONE : S_RUN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8: stalled output beat holds
  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
  // R8: no input accepted during drain
  p_no_input_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  // R9: acknowledge is a single pulse followed by idle
  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (!ack && !busy));
  // R4: a row never runs past the buffer
  p_row_fits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |-> (beat_idx < CNTW'(MAX_COLS)));
  // R6: with no enabled predicate no row qualifies
  p_empty_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (row_done && pred_en == '0) |=> !out_valid);
  // R10: counter is zero in the first busy cycle
  p_cnt_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cyc_count == '0));
endmodule

// File: tb/rowsel_filter_tb.sv
module rowsel_filter_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [3:0]  cfg_sel = 0;
  logic [4:0]  cfg_col = 0;
  logic [2:0]  cfg_op = 0;
  logic        cfg_en = 0;
  logic [31:0] cfg_k = 0;
  logic        start = 0;
  logic        busy, ack, in_ready, out_valid, out_first, out_last;
  logic [31:0] cyc_count, out_data;
  logic        in_valid = 0, in_first = 0, in_last = 0, in_eot = 0;
  logic [31:0] in_data = 0;
  logic        out_ready = 0;

  int n_chk = 0, n_bad = 0;
  logic [33:0] exp_q[$];
  int busy_cnt = 0;
  bit ack_flag = 0, mon_on = 0, prev_stall = 0;
  logic [31:0] prev_data;
  int m_col[16], m_op[16], m_en[16];
  logic [31:0] m_k[16];
  logic [31:0] row[32];

  always #4 clk = ~clk;

  rowsel_filter u_dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit m_cmp(int op, logic [31:0] v, logic [31:0] k);
    int a, b;
    a = v; b = k;
    if (op == 0) return a == b;
    if (op == 1) return a != b;
    if (op == 2) return a < b;
    if (op == 3) return !(a > b);
    if (op == 4) return a > b;
    if (op == 5) return !(a < b);
    return 0;
  endfunction

  function automatic bit m_pass(int len);
    bit res = 0;
    for (int g = 0; g < 4; g++) begin
      bit any_en = 0, all_ok = 1;
      for (int j = 0; j < 4; j++) begin
        int p = g*4 + j;
        if (m_en[p] != 0) begin
          any_en = 1;
          if (!(m_col[p] < len && m_cmp(m_op[p], row[m_col[p]], m_k[p]))) all_ok = 0;
        end
      end
      if (any_en && all_ok) res = 1;
    end
    return res;
  endfunction

  task automatic cfg_load(int sel, int col, int op, int en, logic [31:0] k);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 4'(sel); cfg_col = 5'(col); cfg_op = 3'(op);
    cfg_en = 1'(en); cfg_k = k;
    m_col[sel] = col; m_op[sel] = op; m_en[sel] = en; m_k[sel] = k;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic clear_cfg();
    for (int p = 0; p < 16; p++) cfg_load(p, 0, 0, 0, 0);
  endtask

  // caller sits just after a negedge
  task automatic send_row(int len, bit eot);
    if (m_pass(len))
      for (int b = 0; b < len; b++)
        exp_q.push_back({row[b], b == 0, b == len - 1});
    for (int b = 0; b < len; b++) begin
      while (!in_ready) begin in_valid = 0; @(negedge clk); end
      in_valid = 1; in_data = row[b];
      in_first = (b == 0); in_last = (b == len - 1); in_eot = eot && (b == len - 1);
      @(negedge clk);
    end
    in_valid = 0; in_first = 0; in_last = 0; in_eot = 0;
  endtask

  // kind 0: random rows; kind 1: single-beat rows from vals
  task automatic run_table(int nrows, int kind, logic [31:0] vals[4]);
    @(negedge clk);
    start = 1; busy_cnt = 0;
    @(negedge clk);
    start = 0;
    chk(busy == 1 && in_ready == 1, "R2 run opens", {busy, in_ready}, 3);
    for (int r = 0; r < nrows; r++) begin
      int len;
      if (kind == 1) begin len = 1; row[0] = vals[r % 4]; end
      else begin
        len = (r % 7 == 6) ? 32 : $urandom_range(1, 8);
        for (int b = 0; b < 32; b++) row[b] = 32'($urandom_range(0, 40)) - 32'd20;
      end
      send_row(len, r == nrows - 1);
    end
    wait (ack_flag);
    @(negedge clk); #1;
    ack_flag = 0;
    chk(busy == 0, "R9 idle after ack", busy, 0);
    chk(cyc_count == 32'(busy_cnt), "R10 cycle count", cyc_count, busy_cnt);
    @(negedge clk); #1;
    chk(cyc_count == 32'(busy_cnt), "R10 count holds", cyc_count, busy_cnt);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on) begin
        out_ready = ($urandom_range(0, 3) != 0);
        if (busy) busy_cnt++;
        if (prev_stall)
          chk(out_valid && out_data == prev_data, "R8 hold while stalled", out_data, prev_data);
        if (out_valid)
          chk(in_ready == 0, "R8 input held off", in_ready, 0);
        prev_stall = out_valid && !out_ready;
        prev_data  = out_data;
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) chk(0, "R7 unexpected beat", out_data, 0);
          else begin
            logic [33:0] e;
            e = exp_q.pop_front();
            chk({out_data, out_first, out_last} == e, "R7 beat", {out_data, out_first, out_last}, e);
          end
        end
        if (ack) begin
          chk(exp_q.size() == 0, "R9 ack after drain", exp_q.size(), 0);
          ack_flag = 1;
        end
      end
    end
  end

  initial begin
    bit wd_hit = 0;
    logic [31:0] v[4];
    fork
      begin
        repeat (3) @(negedge clk);
        chk(!out_valid && !ack && !busy && !in_ready, "R1 reset state",
            {out_valid, ack, busy, in_ready}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(!busy && !in_ready, "R1 idle stays", {busy, in_ready}, 0);
        mon_on = 1;
        // R6: empty configuration passes nothing
        v = '{0, 0, 0, 0};
        run_table(5, 0, v);
        // R4 R5: mixed groups, short rows and long rows
        cfg_load(0, 2, 4, 1, 32'd5);
        cfg_load(1, 0, 3, 1, 32'd10);
        cfg_load(4, 5, 2, 1, -32'sd3);
        cfg_load(12, 1, 1, 1, 32'd0);
        cfg_load(13, 31, 5, 1, 32'd0);
        run_table(40, 0, v);
        // R3: operator sweep on single-beat rows, signed values
        v = '{32'd4, 32'd5, 32'd6, -32'sd5};
        clear_cfg();
        for (int op = 0; op < 8; op++) begin
          cfg_load(8, 0, op, 1, 32'd5);
          run_table(8, 1, v);
        end
      end
      begin
        repeat (150000) @(posedge clk);
        wd_hit = 1;
      end
    join_any
    if (wd_hit) chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule